// File: doc/BRIEF.md
# Memory-Mapped Write-Only Output Port

This block places one 8-bit write-only output register at a single location in the 64K address space of a microcontroller with a 16-bit address bus and an 8-bit data bus. The address is decoded in two cascaded stages. The first stage compares the uppermost address bits against fixed values and then picks one of eight coarse regions. The second stage is enabled by the one region that holds the port. It checks the next bits down against fixed values and then picks one of eight 32-byte slots. A final optional compare narrows the hit to one byte. Both stages drive their eight select lines out, active-low, so other peripherals can reuse the free regions and slots.

A write to the port address is qualified by the bus enable strobe and by the read/write line being in its write state. When that strobe ends, the register takes the data byte last seen while the strobe was active. An active-low output enable switches the register outputs to high impedance without disturbing the stored byte. A parameter changes the first stage to 8K blocks. In that setting the selected block is split further by the second stage.

Top module: `mmio_out_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, `q` reads 8'h00 with `oe_n` low.
- R2: A write to `PORT_ADDR` (default 16'h6C6A) with `bus_e` high and `rw` low loads `data_in` into the register. `q` shows the new value from the first clock edge after `bus_e` falls.
- R3: With `rw` high (a read), `port_stb_n` stays high and the register never changes, including at `PORT_ADDR`.
- R4: A write to any address that differs from `PORT_ADDR` leaves the register unchanged, whether it differs in region, upper tag, slot, middle tag or byte offset.
- R5: In the default 1K mode, `region_sel_n` has bit `addr[12:10]` low and all other bits high when `addr[15:13]` equals 3'b011. Otherwise all bits are high.
- R6: `slot_sel_n` has bit `addr[7:5]` low when `region_sel_n[3]` is low and `addr[9:8]` is 2'b00. Otherwise all bits are high.
- R7: `port_stb_n` is low exactly when the address equals `PORT_ADDR`, `bus_e` is high and `rw` is low.
- R8: While `oe_n` is high, `q` is released to high impedance and does not drive the stored byte. Once `oe_n` is low again, the stored byte reappears unchanged.
- R9: If `data_in` changes while the strobe is active, the byte held in the last active cycle is the one stored.
- R10: With `bus_e` low, a write-type cycle at `PORT_ADDR` does not assert `port_stb_n` and does not change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the bus |
| rst_n | input | 1 | Active-low reset; clears the register |
| addr | input | 16 | Bus address |
| data_in | input | 8 | Bus data byte |
| bus_e | input | 1 | Bus enable strobe, high during the data phase |
| rw | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Active-low output enable for `q` |
| q | output | 8 | Register outputs, high impedance while `oe_n` is high |
| region_sel_n | output | 8 | First-stage region selects, active-low |
| slot_sel_n | output | 8 | Second-stage slot selects, active-low |
| port_stb_n | output | 1 | Qualified write strobe for the port, active-low |

## Verification
A decode fault shows up on `region_sel_n`, `slot_sel_n` and `port_stb_n` in the same cycle as the address. A wrong captured byte or a spurious load shows up on `q` at the edge that follows the end of the strobe, so each check samples `q` one clock after `bus_e` drops. A stale stored byte hidden by `oe_n` shows up as soon as the outputs are enabled again. An edge-detect fault shows up as a missing update or a stray update one cycle after a strobe.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int DEC_SEL_W  = 3;
  localparam int DEC_OUTS   = 1 << DEC_SEL_W;
  localparam int SLOT_BITS  = 5;
  typedef enum logic { REGION_1K = 1'b0, BLOCK_8K = 1'b1 } coarse_mode_e;
endpackage

// File: rtl/mmio_dec3to8.sv
module mmio_dec3to8 #(
  parameter int SEL_W = 3,
  localparam int NOUT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [NOUT-1:0]  out_n
);
  for (genvar i = 0; i < NOUT; i++) begin : g_line
    assign out_n[i] = ~(en && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/mmio_wr_qual.sv
module mmio_wr_qual (
  input  logic slot_hit,
  input  logic byte_hit,
  input  logic bus_e,
  input  logic rw,
  output logic stb,
  output logic stb_n
);
  always_comb begin
    stb   = slot_hit && byte_hit && bus_e && !rw;
    stb_n = !stb;
  end
endmodule

// File: rtl/mmio_out_reg.sv
module mmio_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] d,
  input  logic         oe_n,
  output logic [W-1:0] q
);
  logic         stb_q;
  logic [W-1:0] hold;
  logic [W-1:0] store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      hold  <= '0;
      store <= '0;
    end else begin
      stb_q <= stb;
      if (stb) hold <= d;
      if (stb_q && !stb) store <= hold;
    end
  end

  assign q = oe_n ? {W{1'bz}} : store;
endmodule

// File: rtl/mmio_out_port.sv
module mmio_out_port
  import mmio_pkg::*;
#(
  parameter int           ADDR_W     = 16,
  parameter int           DATA_W     = 8,
  parameter logic [15:0]  PORT_ADDR  = 16'h6C6A,
  parameter coarse_mode_e COARSE     = REGION_1K,
  parameter bit           BYTE_EXACT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic              bus_e,
  input  logic              rw,
  input  logic              oe_n,
  output logic [DATA_W-1:0] q,
  output logic [DEC_OUTS-1:0] region_sel_n,
  output logic [DEC_OUTS-1:0] slot_sel_n,
  output logic              port_stb_n
);
  localparam int L1_LSB  = (COARSE == BLOCK_8K) ? 13 : 10;
  localparam int TOP_LSB = L1_LSB + DEC_SEL_W;
  localparam int MID_LSB = SLOT_BITS + DEC_SEL_W;
  localparam logic [DEC_SEL_W-1:0] REGION_IDX = PORT_ADDR[L1_LSB +: DEC_SEL_W];

  logic top_en, mid_en, byte_hit, slot_hit, wr_stb;

  if (TOP_LSB < ADDR_W) begin : g_top_tag
    assign top_en = (addr[ADDR_W-1:TOP_LSB] == PORT_ADDR[ADDR_W-1:TOP_LSB]);
  end else begin : g_no_top_tag
    assign top_en = 1'b1;
  end

  assign mid_en = (addr[L1_LSB-1:MID_LSB] == PORT_ADDR[L1_LSB-1:MID_LSB]);

  if (BYTE_EXACT) begin : g_byte
    assign byte_hit = (addr[SLOT_BITS-1:0] == PORT_ADDR[SLOT_BITS-1:0]);
  end else begin : g_slot_only
    assign byte_hit = 1'b1;
  end

  mmio_dec3to8 #(.SEL_W(DEC_SEL_W)) region_dec_i (
    .en    (top_en),
    .sel   (addr[L1_LSB +: DEC_SEL_W]),
    .out_n (region_sel_n)
  );

  mmio_dec3to8 #(.SEL_W(DEC_SEL_W)) slot_dec_i (
    .en    (!region_sel_n[REGION_IDX] && mid_en),
    .sel   (addr[SLOT_BITS +: DEC_SEL_W]),
    .out_n (slot_sel_n)
  );

  assign slot_hit = !slot_sel_n[PORT_ADDR[SLOT_BITS +: DEC_SEL_W]];

  mmio_wr_qual qual_i (
    .slot_hit (slot_hit),
    .byte_hit (byte_hit),
    .bus_e    (bus_e),
    .rw       (rw),
    .stb      (wr_stb),
    .stb_n    (port_stb_n)
  );

  mmio_out_reg #(.W(DATA_W)) out_reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (wr_stb),
    .d     (data_in),
    .oe_n  (oe_n),
    .q     (q)
  );
endmodule

// File: rtl/mmio_out_port_chk.sv
module mmio_out_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_e,
  input logic         rw,
  input logic         oe_n,
  input logic [W-1:0] q,
  input logic [7:0]   region_sel_n,
  input logic [7:0]   slot_sel_n,
  input logic         port_stb_n
);
  // R5
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~region_sel_n) <= 1);

  // R6
  slot_needs_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel_n != 8'hFF) |-> (region_sel_n != 8'hFF));

  // R7
  stb_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_stb_n |-> (bus_e && !rw));

  // R3
  read_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rw |-> port_stb_n);

  // R2
  load_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !$past(oe_n) && (q != $past(q)))
      |-> ($past(port_stb_n) && !$past(port_stb_n, 2)));
endmodule

bind mmio_out_port mmio_out_port_chk #(.W(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_e        (bus_e),
  .rw           (rw),
  .oe_n         (oe_n),
  .q            (q),
  .region_sel_n (region_sel_n),
  .slot_sel_n   (slot_sel_n),
  .port_stb_n   (port_stb_n)
);

// File: tb/mmio_out_port_tb.sv
module mmio_out_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data_in = 8'h00;
  logic        bus_e = 1'b0;
  logic        rw = 1'b1;
  logic        oe_n = 1'b0;
  logic [7:0]  q;
  logic [7:0]  region_sel_n, slot_sel_n;
  logic        port_stb_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mmio_out_port dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data_in(data_in),
    .bus_e(bus_e), .rw(rw), .oe_n(oe_n), .q(q),
    .region_sel_n(region_sel_n), .slot_sel_n(slot_sel_n),
    .port_stb_n(port_stb_n)
  );

  localparam logic [15:0] PORT = 16'h6C6A;
  localparam int NVEC = 9;
  // {addr, data, rw, expected q}
  localparam logic [32:0] VEC [NVEC] = '{
    {16'h6C6A, 8'hA5, 1'b0, 8'hA5},
    {16'h6C6A, 8'h3C, 1'b1, 8'hA5},
    {16'h6C6B, 8'h11, 1'b0, 8'hA5},
    {16'h6C4A, 8'h22, 1'b0, 8'hA5},
    {16'h6E6A, 8'h33, 1'b0, 8'hA5},
    {16'h686A, 8'h44, 1'b0, 8'hA5},
    {16'hEC6A, 8'h55, 1'b0, 8'hA5},
    {16'h6C6A, 8'h00, 1'b0, 8'h00},
    {16'h6C6A, 8'hFF, 1'b0, 8'hFF}
  };

  function automatic logic [7:0] exp_region(input logic [15:0] a);
    return (a[15:13] == 3'b011) ? ~(8'b1 << a[12:10]) : 8'hFF;
  endfunction

  function automatic logic [7:0] exp_slot(input logic [15:0] a);
    return (a[15:10] == 6'b011011 && a[9:8] == 2'b00) ? ~(8'b1 << a[7:5]) : 8'hFF;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic r,
                           output logic stb_seen);
    @(negedge clk);
    addr = a; data_in = d; rw = r; bus_e = 1'b1;
    @(negedge clk);
    stb_seen = port_stb_n;
    @(negedge clk);
    bus_e = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic s;
    repeat (3) @(negedge clk);
    check8("R1 in reset", q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R1 after reset", q, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] a;
      logic [7:0] d, e;
      logic r;
      {a, d, r, e} = VEC[i];
      bus_cycle(a, d, r, s);
      if (r) begin
        check8("R3 read strobe", {7'b0, s}, 8'h01);
        check8("R3 read keeps q", q, e);
      end else if (a == PORT) begin
        check8("R7 strobe at port", {7'b0, s}, 8'h00);
        check8("R2 write loads", q, e);
      end else begin
        check8("R7 strobe off port", {7'b0, s}, 8'h01);
        check8("R4 miss keeps q", q, e);
      end
    end

    // decoder selects
    begin
      logic [15:0] probes [6] = '{16'h6C6A, 16'h7400, 16'h8000, 16'h0CE0, 16'h6D00, 16'h6CE0};
      foreach (probes[k]) begin
        @(negedge clk);
        addr = probes[k]; rw = 1'b1; bus_e = 1'b0;
        @(negedge clk);
        check8("R5 region select", region_sel_n, exp_region(probes[k]));
        check8("R6 slot select", slot_sel_n, exp_slot(probes[k]));
      end
    end

    // R9: data changes during the strobe
    @(negedge clk);
    addr = PORT; rw = 1'b0; data_in = 8'h11; bus_e = 1'b1;
    @(negedge clk);
    data_in = 8'h77;
    @(negedge clk);
    bus_e = 1'b0;
    @(negedge clk);
    check8("R9 last byte kept", q, 8'h77);

    // R10: enable strobe absent
    @(negedge clk);
    addr = PORT; rw = 1'b0; data_in = 8'h99; bus_e = 1'b0;
    @(negedge clk);
    check8("R10 no strobe", {7'b0, port_stb_n}, 8'h01);
    repeat (2) @(negedge clk);
    check8("R10 q unchanged", q, 8'h77);

    // R8: outputs released, value retained
    oe_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (q === 8'h77) begin
      n_bad++;
      $display("FAIL R8 released: got %h expected zz", q);
    end
    oe_n = 1'b0;
    @(negedge clk);
    check8("R8 value restored", q, 8'h77);

    // R1: reset clears a loaded register
    rst_n = 1'b0;
    @(negedge clk);
    check8("R1 reset clears", q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule